// File: doc/BRIEF.md
# Configuration ROM Record Locator

This block scans a device self-description area kept in 32-bit registers and reports where the records of interest sit. A one-cycle `start` begins the scan. The block reads registers through a plain synchronous port: it raises `rd_en` with an address, and the data comes back on `rd_data` one cycle later. Only the low half of each word carries information.

The description area is a chain of records. Each record begins with a 16-bit header that holds a type code and a payload length counted in words. The block first probes the primary area. If that area is empty, it switches to an alternate area. It then follows the chain until it reaches an end marker. It keeps the location and length of four records:
- the first text label;
- the first integer, which is the content hash;
- the second integer, which is the revision;
- the first compressed blob.

The block does not decode payload contents; other logic reads them using the reported addresses. If a header would take the chain outside the active area, the scan stops with an error.

Top module: `cfgrom_locator`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `alt_used`, `rd_en` and every `*_found` output are 0.
- R2: When `start` is accepted, the first read goes to the primary base word. If bits [15:0] of that word are zero (bits [31:16] do not matter), the scan moves to the alternate base word and sets `alt_used`. Otherwise that same word is taken as the first header.
- R3: In a header word, bits [15:14] are the type and bits [13:0] are the payload length in words. Bits [31:16] are ignored. The next header sits at header address + 1 + length.
- R4: A header of type 0 ends the scan whatever its length bits hold: `done` goes to 1 and `busy` goes to 0.
- R5: For the first type-1 record, `lbl_found` is set, `lbl_addr` gives the address of its first payload word, and `lbl_len` gives its length. Later type-1 records change nothing.
- R6: The first type-2 record fills the `hash_*` outputs and the second fills the `rev_*` outputs. Any further type-2 records change nothing.
- R7: The first type-3 record fills the `blob_*` outputs. Later type-3 records change nothing.
- R8: If header address + 1 + length is greater than the last word of the active area, the scan stops with `err`=1 and `done`=1, and that record is not reported. A next-header address equal to the last word is legal.
- R9: Every read address lies within the primary area or the alternate area, and at most one read is issued every two cycles.
- R10: `done` is seen 2k cycles after the cycle in which `start` was sampled, where k is the number of words the scan read (the probe word included).
- R11: `start` is ignored while `busy` is 1. An accepted `start` clears `done`, `err`, `alt_used` and all `*_found` outputs before the new scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan (accepted only while idle) |
| rd_en | output | 1 | Register read strobe |
| rd_addr | output | 24 | Register word address |
| rd_data | input | 32 | Read data, valid one cycle after `rd_en` |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished; held until the next accepted start |
| err | output | 1 | Scan stopped on an area overrun |
| alt_used | output | 1 | Alternate area was scanned |
| lbl_found | output | 1 | Text label record found |
| lbl_addr | output | 24 | First payload word of the label |
| lbl_len | output | 14 | Label payload length in words |
| hash_found | output | 1 | First integer record found |
| hash_addr | output | 24 | First payload word of the hash |
| hash_len | output | 14 | Hash payload length in words |
| rev_found | output | 1 | Second integer record found |
| rev_addr | output | 24 | First payload word of the revision |
| rev_len | output | 14 | Revision payload length in words |
| blob_found | output | 1 | Compressed blob record found |
| blob_addr | output | 24 | First payload word of the blob |
| blob_len | output | 14 | Blob payload length in words |

## Verification
The bench keeps both base addresses at their defaults but shrinks each area to 64 words (last words 0x83F and 0x403F). With areas that small, a single header can run past the end of either area. This makes the overrun abort, and the legal case where the next header lands exactly on the last word, reachable with small images. The small areas also let the bench model back the full address range of both areas, so any read outside them is caught.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;

    localparam int ROM_AW    = 24;
    localparam int LEN_W     = 14;
    localparam int NUM_SLOTS = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PREQ,
        S_PDAT,
        S_DREQ,
        S_DDAT
    } walk_st_e;

    typedef struct packed {
        logic              found;
        logic [ROM_AW-1:0] addr;
        logic [LEN_W-1:0]  len;
    } rec_t;

    // Slot table: 0 label, 1 hash, 2 revision, 3 blob
    function automatic logic [1:0] slot_kind(input int s);
        case (s)
            0:       return 2'd1;
            1:       return 2'd2;
            2:       return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    // Which occurrence (0-based) of its kind a slot keeps
    function automatic logic [1:0] slot_occ(input int s);
        return (s == 2) ? 2'd1 : 2'd0;
    endfunction

endpackage

// File: rtl/cfgrom_walk.sv
module cfgrom_walk
    import cfgrom_pkg::*;
#(
    parameter logic [ROM_AW-1:0] PRI_BASE = 24'h000800,
    parameter logic [ROM_AW-1:0] PRI_LAST = 24'h000FFF,
    parameter logic [ROM_AW-1:0] ALT_BASE = 24'h004000,
    parameter logic [ROM_AW-1:0] ALT_LAST = 24'h007FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       word_lo,
    output logic              rd_en,
    output logic [ROM_AW-1:0] rd_addr,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              alt_used,
    output logic              ev_valid,
    output logic [1:0]        ev_kind,
    output logic [ROM_AW-1:0] ev_addr,
    output logic [LEN_W-1:0]  ev_len,
    output logic              clr
);

    localparam int SUM_W = ROM_AW + 1;

    typedef struct packed {
        walk_st_e          st;
        logic              rd_en;
        logic [ROM_AW-1:0] rd_addr;
        logic [ROM_AW-1:0] hdr;
        logic [ROM_AW-1:0] last;
        logic              busy;
        logic              done;
        logic              err;
        logic              alt;
        logic              ev_valid;
        logic [1:0]        ev_kind;
        logic [ROM_AW-1:0] ev_addr;
        logic [LEN_W-1:0]  ev_len;
        logic              clr;
    } walk_s;

    localparam walk_s W_RST = '{st: S_IDLE, default: '0};

    walk_s q, d;

    logic [1:0]       w_kind;
    logic [LEN_W-1:0] w_len;
    logic [SUM_W-1:0] nxt_sum;
    logic             do_dec;

    always_comb begin
        w_kind  = word_lo[15:14];
        w_len   = word_lo[LEN_W-1:0];
        nxt_sum = {1'b0, q.hdr} + SUM_W'(1) + SUM_W'(w_len);
        do_dec  = (q.st == S_DDAT) || ((q.st == S_PDAT) && (word_lo != 16'h0000));

        d          = q;
        d.rd_en    = 1'b0;
        d.ev_valid = 1'b0;
        d.clr      = 1'b0;

        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.clr     = 1'b1;
                    d.busy    = 1'b1;
                    d.done    = 1'b0;
                    d.err     = 1'b0;
                    d.alt     = 1'b0;
                    d.rd_en   = 1'b1;
                    d.rd_addr = PRI_BASE;
                    d.hdr     = PRI_BASE;
                    d.last    = PRI_LAST;
                    d.st      = S_PREQ;
                end
            end
            S_PREQ: d.st = S_PDAT;
            S_PDAT: begin
                if (word_lo == 16'h0000) begin
                    d.alt     = 1'b1;
                    d.rd_en   = 1'b1;
                    d.rd_addr = ALT_BASE;
                    d.hdr     = ALT_BASE;
                    d.last    = ALT_LAST;
                    d.st      = S_DREQ;
                end
            end
            S_DREQ: d.st = S_DDAT;
            default: ;
        endcase

        if (do_dec) begin
            if (w_kind == 2'd0) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                d.st   = S_IDLE;
            end else if (nxt_sum > {1'b0, q.last}) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                d.err  = 1'b1;
                d.st   = S_IDLE;
            end else begin
                d.ev_valid = 1'b1;
                d.ev_kind  = w_kind;
                d.ev_addr  = q.hdr + ROM_AW'(1);
                d.ev_len   = w_len;
                d.rd_en    = 1'b1;
                d.rd_addr  = nxt_sum[ROM_AW-1:0];
                d.hdr      = nxt_sum[ROM_AW-1:0];
                d.st       = S_DREQ;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= W_RST;
        else        q <= d;
    end

    assign rd_en    = q.rd_en;
    assign rd_addr  = q.rd_addr;
    assign busy     = q.busy;
    assign done     = q.done;
    assign err      = q.err;
    assign alt_used = q.alt;
    assign ev_valid = q.ev_valid;
    assign ev_kind  = q.ev_kind;
    assign ev_addr  = q.ev_addr;
    assign ev_len   = q.ev_len;
    assign clr      = q.clr;

    a_r9_read_in_area: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (q.alt ? (rd_addr >= ALT_BASE && rd_addr <= ALT_LAST)
                         : (rd_addr >= PRI_BASE && rd_addr <= PRI_LAST)));

    a_r9_read_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

    a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !rd_en);

    a_r8_err_done: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    a_r8_event_in_area: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> (ev_addr <= q.last) && busy);

    a_r2_alt_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alt_used) |-> busy && rd_en && rd_addr == ALT_BASE);

endmodule

// File: rtl/cfgrom_capture.sv
module cfgrom_capture
    import cfgrom_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       ev_valid,
    input  logic [1:0]                 ev_kind,
    input  logic [ROM_AW-1:0]          ev_addr,
    input  logic [LEN_W-1:0]           ev_len,
    output rec_t [NUM_SLOTS-1:0]       slots
);

    typedef struct packed {
        logic [3:0][1:0]       seen;
        rec_t [NUM_SLOTS-1:0]  slot;
    } cap_s;

    cap_s q, d;

    always_comb begin
        d = q;
        if (clr) begin
            d = '0;
        end else if (ev_valid) begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (!q.slot[s].found && ev_kind == slot_kind(s)
                    && q.seen[ev_kind] == slot_occ(s)) begin
                    d.slot[s].found = 1'b1;
                    d.slot[s].addr  = ev_addr;
                    d.slot[s].len   = ev_len;
                end
            end
            if (q.seen[ev_kind] != 2'd3)
                d.seen[ev_kind] = q.seen[ev_kind] + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign slots = q.slot;

    logic [NUM_SLOTS-1:0] fnd;
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign fnd[g] = q.slot[g].found;

        a_r5_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (q.slot[g].found && !clr) |=> q.slot[g].found
                && $stable(q.slot[g].addr) && $stable(q.slot[g].len));
    end

    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> $countones(fnd) == 0);

    a_r6_rev_after_hash: assert property (@(posedge clk) disable iff (!rst_n)
        fnd[2] |-> fnd[1]);

endmodule

// File: rtl/cfgrom_locator.sv
module cfgrom_locator
    import cfgrom_pkg::*;
#(
    parameter logic [ROM_AW-1:0] PRI_BASE = 24'h000800,
    parameter logic [ROM_AW-1:0] PRI_LAST = 24'h000FFF,
    parameter logic [ROM_AW-1:0] ALT_BASE = 24'h004000,
    parameter logic [ROM_AW-1:0] ALT_LAST = 24'h007FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              rd_en,
    output logic [ROM_AW-1:0] rd_addr,
    input  logic [31:0]       rd_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              alt_used,
    output logic              lbl_found,
    output logic [ROM_AW-1:0] lbl_addr,
    output logic [LEN_W-1:0]  lbl_len,
    output logic              hash_found,
    output logic [ROM_AW-1:0] hash_addr,
    output logic [LEN_W-1:0]  hash_len,
    output logic              rev_found,
    output logic [ROM_AW-1:0] rev_addr,
    output logic [LEN_W-1:0]  rev_len,
    output logic              blob_found,
    output logic [ROM_AW-1:0] blob_addr,
    output logic [LEN_W-1:0]  blob_len
);

    logic                 ev_valid;
    logic [1:0]           ev_kind;
    logic [ROM_AW-1:0]    ev_addr;
    logic [LEN_W-1:0]     ev_len;
    logic                 clr;
    rec_t [NUM_SLOTS-1:0] slots;
    logic                 unused_hi;

    assign unused_hi = ^rd_data[31:16];

    cfgrom_walk #(
        .PRI_BASE(PRI_BASE),
        .PRI_LAST(PRI_LAST),
        .ALT_BASE(ALT_BASE),
        .ALT_LAST(ALT_LAST)
    ) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .word_lo  (rd_data[15:0]),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .busy     (busy),
        .done     (done),
        .err      (err),
        .alt_used (alt_used),
        .ev_valid (ev_valid),
        .ev_kind  (ev_kind),
        .ev_addr  (ev_addr),
        .ev_len   (ev_len),
        .clr      (clr)
    );

    cfgrom_capture u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .ev_valid (ev_valid),
        .ev_kind  (ev_kind),
        .ev_addr  (ev_addr),
        .ev_len   (ev_len),
        .slots    (slots)
    );

    assign lbl_found  = slots[0].found;
    assign lbl_addr   = slots[0].addr;
    assign lbl_len    = slots[0].len;
    assign hash_found = slots[1].found;
    assign hash_addr  = slots[1].addr;
    assign hash_len   = slots[1].len;
    assign rev_found  = slots[2].found;
    assign rev_addr   = slots[2].addr;
    assign rev_len    = slots[2].len;
    assign blob_found = slots[3].found;
    assign blob_addr  = slots[3].addr;
    assign blob_len   = slots[3].len;

endmodule

// File: tb/cfgrom_locator_bench.sv
`timescale 1ns/1ps
module cfgrom_locator_bench;

    localparam logic [23:0] PB = 24'h000800;
    localparam logic [23:0] PL = 24'h00083F;
    localparam logic [23:0] AB = 24'h004000;
    localparam logic [23:0] AL = 24'h00403F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_en;
    logic [23:0] rd_addr;
    logic [31:0] rd_data = '0;
    logic        busy, done, err, alt_used;
    logic        lbl_found, hash_found, rev_found, blob_found;
    logic [23:0] lbl_addr, hash_addr, rev_addr, blob_addr;
    logic [13:0] lbl_len, hash_len, rev_len, blob_len;

    int nchk = 0;
    int nfail = 0;

    logic [31:0] pri_mem [64];
    logic [31:0] alt_mem [64];

    always #2.5 clk = ~clk;

    cfgrom_locator #(
        .PRI_BASE(PB), .PRI_LAST(PL), .ALT_BASE(AB), .ALT_LAST(AL)
    ) u_cfgrom_locator (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .done(done), .err(err), .alt_used(alt_used),
        .lbl_found(lbl_found), .lbl_addr(lbl_addr), .lbl_len(lbl_len),
        .hash_found(hash_found), .hash_addr(hash_addr), .hash_len(hash_len),
        .rev_found(rev_found), .rev_addr(rev_addr), .rev_len(rev_len),
        .blob_found(blob_found), .blob_addr(blob_addr), .blob_len(blob_len)
    );

    // Register model: data one cycle after the strobe; reads outside both areas fail R9
    always @(posedge clk) begin
        if (rd_en) begin
            if (rd_addr >= PB && rd_addr <= PL) rd_data <= pri_mem[rd_addr - PB];
            else if (rd_addr >= AB && rd_addr <= AL) rd_data <= alt_mem[rd_addr - AB];
            else begin
                rd_data <= 32'hDEAD_0000;
                nfail   <= nfail + 1;
                $display("FAIL R9: actual read address %0h expected inside an area", rd_addr);
            end
        end
    end

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic              alt;
        logic [0:5][15:0]  d;
        logic              err;
        logic [0:3]        found;
        logic [0:3][23:0]  addr;
        logic [0:3][13:0]  len;
        logic [7:0]        cyc;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{alt:1'b0, d:'{16'h4003,16'h0000,16'h0,16'h0,16'h0,16'h0}, err:1'b0, found:4'b1000,
          addr:'{24'h801,24'h0,24'h0,24'h0}, len:'{14'd3,14'd0,14'd0,14'd0}, cyc:8'd4},
        '{alt:1'b0, d:'{16'h8005,16'h4002,16'h800A,16'hC004,16'h0000,16'h0}, err:1'b0, found:4'b1111,
          addr:'{24'h807,24'h801,24'h80A,24'h815}, len:'{14'd2,14'd5,14'd10,14'd4}, cyc:8'd10},
        '{alt:1'b0, d:'{16'h4001,16'h4004,16'h8001,16'h8002,16'h8003,16'hC000}, err:1'b0, found:4'b1111,
          addr:'{24'h801,24'h808,24'h80A,24'h811}, len:'{14'd1,14'd1,14'd2,14'd0}, cyc:8'd14},
        '{alt:1'b1, d:'{16'hC003,16'h0000,16'h0,16'h0,16'h0,16'h0}, err:1'b0, found:4'b0001,
          addr:'{24'h0,24'h0,24'h0,24'h4001}, len:'{14'd0,14'd0,14'd0,14'd3}, cyc:8'd6},
        '{alt:1'b0, d:'{16'h4040,16'h0,16'h0,16'h0,16'h0,16'h0}, err:1'b1, found:4'b0000,
          addr:'{24'h0,24'h0,24'h0,24'h0}, len:'{14'd0,14'd0,14'd0,14'd0}, cyc:8'd2},
        '{alt:1'b0, d:'{16'h803E,16'h0000,16'h0,16'h0,16'h0,16'h0}, err:1'b0, found:4'b0100,
          addr:'{24'h0,24'h801,24'h0,24'h0}, len:'{14'd0,14'd62,14'd0,14'd0}, cyc:8'd4},
        '{alt:1'b0, d:'{16'h803F,16'h0,16'h0,16'h0,16'h0,16'h0}, err:1'b1, found:4'b0000,
          addr:'{24'h0,24'h0,24'h0,24'h0}, len:'{14'd0,14'd0,14'd0,14'd0}, cyc:8'd2},
        '{alt:1'b0, d:'{16'h4001,16'h0025,16'h0,16'h0,16'h0,16'h0}, err:1'b0, found:4'b1000,
          addr:'{24'h801,24'h0,24'h0,24'h0}, len:'{14'd1,14'd0,14'd0,14'd0}, cyc:8'd4},
        '{alt:1'b1, d:'{16'h4040,16'h0,16'h0,16'h0,16'h0,16'h0}, err:1'b1, found:4'b0000,
          addr:'{24'h0,24'h0,24'h0,24'h0}, len:'{14'd0,14'd0,14'd0,14'd0}, cyc:8'd4},
        '{alt:1'b0, d:'{16'hC001,16'hC002,16'h4003,16'h0000,16'h0,16'h0}, err:1'b0, found:4'b1001,
          addr:'{24'h806,24'h0,24'h0,24'h801}, len:'{14'd3,14'd0,14'd0,14'd1}, cyc:8'd8}
    };

    task automatic put(input logic alt, input int a, input logic [31:0] w);
        if (a < 64) begin
            if (alt) alt_mem[a] = w;
            else     pri_mem[a] = w;
        end
    endtask

    // Header words carry junk in bits [31:16] (R3); payload is non-zero filler
    task automatic load(input vec_t v);
        int a;
        logic [15:0] w;
        a = 0;
        for (int i = 0; i < 64; i++) begin
            pri_mem[i] = '0;
            alt_mem[i] = '0;
        end
        for (int i = 0; i < 6; i++) begin
            w = v.d[i];
            put(v.alt, a, {16'h5A5A, w});
            if (w[15:14] == 2'd0) break;
            for (int j = 1; j <= int'(w[13:0]); j++) put(v.alt, a + j, 32'h0000_A5A5);
            a = a + 1 + int'(w[13:0]);
            if (a > 63) break;
        end
    endtask

    // Returns posedges counted after the start-sampling edge until done is seen
    task automatic run(input int extra_at, output int cyc);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            start = (cyc == extra_at);
            if (done || cyc > 2000) break;
        end
        start = 1'b0;
    endtask

    task automatic check_vec(input vec_t v, input int cyc);
        cmp("R4 done", {31'b0, done}, 32'd1);
        cmp("R4 busy low", {31'b0, busy}, 32'd0);
        cmp("R8 err", {31'b0, err}, {31'b0, v.err});
        cmp("R2 alt_used", {31'b0, alt_used}, {31'b0, v.alt});
        cmp("R3 R10 cycles", cyc, {24'b0, v.cyc});
        cmp("R5 lbl_found", {31'b0, lbl_found}, {31'b0, v.found[0]});
        cmp("R6 hash_found", {31'b0, hash_found}, {31'b0, v.found[1]});
        cmp("R6 rev_found", {31'b0, rev_found}, {31'b0, v.found[2]});
        cmp("R7 blob_found", {31'b0, blob_found}, {31'b0, v.found[3]});
        if (v.found[0]) begin
            cmp("R5 lbl_addr", {8'b0, lbl_addr}, {8'b0, v.addr[0]});
            cmp("R5 lbl_len", {18'b0, lbl_len}, {18'b0, v.len[0]});
        end
        if (v.found[1]) begin
            cmp("R6 hash_addr", {8'b0, hash_addr}, {8'b0, v.addr[1]});
            cmp("R6 hash_len", {18'b0, hash_len}, {18'b0, v.len[1]});
        end
        if (v.found[2]) begin
            cmp("R6 rev_addr", {8'b0, rev_addr}, {8'b0, v.addr[2]});
            cmp("R6 rev_len", {18'b0, rev_len}, {18'b0, v.len[2]});
        end
        if (v.found[3]) begin
            cmp("R7 blob_addr", {8'b0, blob_addr}, {8'b0, v.addr[3]});
            cmp("R7 blob_len", {18'b0, blob_len}, {18'b0, v.len[3]});
        end
    endtask

    logic finished = 1'b0;

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int cyc;
        vec_t v;
        for (int i = 0; i < 64; i++) begin
            pri_mem[i] = '0;
            alt_mem[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        cmp("R1 busy", {31'b0, busy}, 32'd0);
        cmp("R1 done", {31'b0, done}, 32'd0);
        cmp("R1 err", {31'b0, err}, 32'd0);
        cmp("R1 alt_used", {31'b0, alt_used}, 32'd0);
        cmp("R1 rd_en", {31'b0, rd_en}, 32'd0);
        cmp("R1 found", {28'b0, lbl_found, hash_found, rev_found, blob_found}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // Vector table walk (each start also checks R11 clearing of the previous run)
        for (int n = 0; n < NV; n++) begin
            load(VEC[n]);
            run(-1, cyc);
            check_vec(VEC[n], cyc);
        end

        // R2: probe word with only its upper half set selects the alternate area
        v = '{alt:1'b1, d:'{16'h4002,16'h0000,16'h0,16'h0,16'h0,16'h0}, err:1'b0, found:4'b1000,
              addr:'{24'h4001,24'h0,24'h0,24'h0}, len:'{14'd2,14'd0,14'd0,14'd0}, cyc:8'd6};
        load(v);
        pri_mem[0] = 32'hFFFF_0000;
        run(-1, cyc);
        check_vec(v, cyc);

        // R11: a second start during a scan is ignored
        load(VEC[1]);
        run(3, cyc);
        check_vec(VEC[1], cyc);
        cmp("R11 no restart", {31'b0, busy}, 32'd0);

        // R11: restart from a full result set into an overrun clears all found flags
        load(VEC[6]);
        run(-1, cyc);
        check_vec(VEC[6], cyc);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule